// File: doc/BRIEF.md
# Bus Width Matcher With Byte-Order Select

This block sits between a producer and a consumer that may use different word widths. It converts a stream of 18-bit words into a stream of 9-bit words, or the reverse. It can also pass words through unchanged when both sides use the same width. Each side picks its width independently through a mode pin. The byte order used for splitting and packing comes from a third mode pin. All three pins are captured while master reset is held. After that, the pins have no effect until the next reset.

Each side uses a valid/ready handshake. A 9-bit word always travels on the low nine bits of its bus. When a wide word is split, the half that is read first depends on the byte order. With big-endian order, the upper half goes out first. With little-endian order, the lower half goes out first. When two narrow words are packed, the first one received is placed in the half that would be read out first. A half-packed word is not offered downstream until its partner arrives. The block runs on one clock.

Top module: `bus_width_matcher`

## Requirements
- R1: The three mode pins are sampled only while `rstN` is low. Changing them after reset leaves the conversion unchanged.
- R2: With `cfgWrNarrow`=0 and `cfgRdNarrow`=0, every 18-bit input word is delivered whole and in order.
- R3: With `cfgWrNarrow`=0, `cfgRdNarrow`=1 and `cfgBigEnd`=1, each input word W gives two outputs: W[17:9] first, then W[8:0]. Each is placed on `outData[8:0]`. While the output is in 9-bit mode, `outData[17:9]` reads zero whenever `outValid` is high.
- R4: With `cfgWrNarrow`=0, `cfgRdNarrow`=1 and `cfgBigEnd`=0, the order is W[8:0] first, then W[17:9].
- R5: With `cfgWrNarrow`=1 and `cfgRdNarrow`=0, two inputs A then B (taken from `inData[8:0]`) form the output {A,B} when `cfgBigEnd`=1 and {B,A} when `cfgBigEnd`=0.
- R6: While only one half of a packed word has been received, `outValid` stays low.
- R7: With both width pins high, `inData[8:0]` passes through in order. `inData[17:9]` is ignored.
- R8: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` holds its value.
- R9: Master reset discards any partially packed or partially split word. After reset `outValid` is low, and the next two narrow inputs form a fresh word.
- R10: In split mode no new wide word is accepted on the cycle after one is taken. The block holds it until both halves have left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous master reset, active low; mode pins sampled while low |
| cfgWrNarrow | input | 1 | Write side width: 0 = 18-bit, 1 = 9-bit |
| cfgRdNarrow | input | 1 | Read side width: 0 = 18-bit, 1 = 9-bit |
| cfgBigEnd | input | 1 | Byte order: 1 = upper half first, 0 = lower half first |
| inValid | input | 1 | Producer offers a word |
| inReady | output | 1 | Block can take a word this cycle |
| inData | input | 18 | Input word; 9-bit mode uses bits 8:0 |
| outValid | output | 1 | Block offers a word |
| outReady | input | 1 | Consumer takes the word this cycle |
| outData | output | 18 | Output word; 9-bit mode uses bits 8:0, upper bits zero |

## Verification
The hardest state to reach is a reset that lands while a packed word holds only one half. The bench first sends a single narrow word in pack mode and confirms that nothing is offered. It then pulses master reset and sends a new pair. The output must contain only the new pair, with no trace of the discarded half. A second hard case is consumer back-pressure in the middle of a split. The bench holds `outReady` low for several cycles while only the second half remains. It checks that the data holds and that the input side stays closed.

// File: rtl/bus_width_matcher_pkg.sv
package bus_width_matcher_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_HALF  = 2'd1,
    ST_FULL  = 2'd2
  } holdState_t;

  typedef struct packed {
    logic loadAll;
    logic loadFirst;
    logic loadSecond;
    logic pickSecond;
    logic pickLow;
  } ctlStrobes_t;

endpackage

// File: rtl/bus_width_matcher_ctrl.sv
module bus_width_matcher_ctrl
  import bus_width_matcher_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrNarrow,
  input  logic        cfgRdNarrow,
  input  logic        cfgBigEnd,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic        wrNarrowQ,
  output logic        rdNarrowQ,
  output logic        bigEndQ,
  output ctlStrobes_t strobes
);

  holdState_t state, stateNext;
  logic passMode, splitMode, packMode;
  logic inFire, outFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrNarrowQ <= cfgWrNarrow;
      rdNarrowQ <= cfgRdNarrow;
      bigEndQ   <= cfgBigEnd;
      state     <= ST_EMPTY;
    end else begin
      state <= stateNext;
    end
  end

  assign passMode  = (wrNarrowQ == rdNarrowQ);
  assign splitMode = !wrNarrowQ && rdNarrowQ;
  assign packMode  = wrNarrowQ && !rdNarrowQ;

  always_comb begin
    inReady  = 1'b0;
    outValid = 1'b0;
    if (passMode) begin
      outValid = (state == ST_FULL);
      inReady  = (state == ST_EMPTY) || ((state == ST_FULL) && outReady);
    end else if (splitMode) begin
      outValid = (state != ST_EMPTY);
      inReady  = (state == ST_EMPTY) || ((state == ST_HALF) && outReady);
    end else if (packMode) begin
      outValid = (state == ST_FULL);
      inReady  = (state != ST_FULL) || outReady;
    end
  end

  assign inFire  = inValid && inReady;
  assign outFire = outValid && outReady;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    strobes.pickLow    = passMode;
    strobes.pickSecond = splitMode && (state == ST_HALF);
    if (passMode || splitMode) begin
      strobes.loadAll = inFire;
      unique case (state)
        ST_EMPTY: if (inFire) stateNext = ST_FULL;
        ST_FULL:  if (outFire) stateNext = passMode ? (inFire ? ST_FULL : ST_EMPTY) : ST_HALF;
        ST_HALF:  if (outFire) stateNext = inFire ? ST_FULL : ST_EMPTY;
        default:  stateNext = ST_EMPTY;
      endcase
    end else if (packMode) begin
      unique case (state)
        ST_EMPTY: if (inFire) begin
          strobes.loadFirst = 1'b1;
          stateNext = ST_HALF;
        end
        ST_HALF: if (inFire) begin
          strobes.loadSecond = 1'b1;
          stateNext = ST_FULL;
        end
        ST_FULL: if (outFire) begin
          strobes.loadFirst = inFire;
          stateNext = inFire ? ST_HALF : ST_EMPTY;
        end
        default: stateNext = ST_EMPTY;
      endcase
    end
  end

endmodule

// File: rtl/bus_width_matcher_dp.sv
module bus_width_matcher_dp
  import bus_width_matcher_pkg::*;
#(
  parameter int HALF_W = 9,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              bigEnd,
  input  logic              rdNarrow,
  input  logic [FULL_W-1:0] inData,
  output logic [FULL_W-1:0] outData
);

  logic [FULL_W-1:0] holdReg;
  logic [HALF_W-1:0] upperHalf, lowerHalf, narrowOut;
  logic writeUpper, writeLower;

  assign upperHalf  = holdReg[FULL_W-1:HALF_W];
  assign lowerHalf  = holdReg[HALF_W-1:0];
  assign writeUpper = (strobes.loadFirst && bigEnd) || (strobes.loadSecond && !bigEnd);
  assign writeLower = (strobes.loadFirst && !bigEnd) || (strobes.loadSecond && bigEnd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobes.loadAll) begin
      holdReg <= inData;
    end else begin
      if (writeUpper) holdReg[FULL_W-1:HALF_W] <= inData[HALF_W-1:0];
      if (writeLower) holdReg[HALF_W-1:0]      <= inData[HALF_W-1:0];
    end
  end

  always_comb begin
    if (strobes.pickLow)                  narrowOut = lowerHalf;
    else if (strobes.pickSecond ^ bigEnd) narrowOut = upperHalf;
    else                                  narrowOut = lowerHalf;
  end

  assign outData = rdNarrow ? {{HALF_W{1'b0}}, narrowOut} : holdReg;

endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
  import bus_width_matcher_pkg::*;
#(
  parameter int HALF_W = 9,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrNarrow,
  input  logic              cfgRdNarrow,
  input  logic              cfgBigEnd,
  input  logic              inValid,
  output logic              inReady,
  input  logic [FULL_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [FULL_W-1:0] outData
);

  ctlStrobes_t strobes;
  logic wrNarrowQ, rdNarrowQ, bigEndQ;

  bus_width_matcher_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrNarrow(cfgWrNarrow), .cfgRdNarrow(cfgRdNarrow), .cfgBigEnd(cfgBigEnd),
    .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid),
    .wrNarrowQ(wrNarrowQ), .rdNarrowQ(rdNarrowQ), .bigEndQ(bigEndQ),
    .strobes(strobes)
  );

  bus_width_matcher_dp #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .bigEnd(bigEndQ), .rdNarrow(rdNarrowQ),
    .inData(inData), .outData(outData)
  );

endmodule

// File: rtl/bus_width_matcher_chk.sv
module bus_width_matcher_chk #(
  parameter int HALF_W = 9,
  localparam int FULL_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [FULL_W-1:0] outData,
  input logic              wrNarrow,
  input logic              rdNarrow,
  input logic              bigEnd
);

  logic packMode, splitMode, oddHalves;
  assign packMode  = wrNarrow && !rdNarrow;
  assign splitMode = !wrNarrow && rdNarrow;

  always_ff @(posedge clk) begin
    if (!rstN) oddHalves <= 1'b0;
    else if (inValid && inReady) oddHalves <= !oddHalves;
  end

  p_cfg_locked_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(wrNarrow) && $stable(rdNarrow) && $stable(bigEnd)));

  p_narrow_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && rdNarrow) |-> (outData[FULL_W-1:HALF_W] == '0));

  p_partial_hidden_r6: assert property (@(posedge clk) disable iff (!rstN)
    (packMode && oddHalves) |-> !outValid);

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  p_split_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    (splitMode && inValid && inReady) |=> !inReady);

endmodule

bind bus_width_matcher bus_width_matcher_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .wrNarrow(wrNarrowQ), .rdNarrow(rdNarrowQ), .bigEnd(bigEndQ)
);

// File: tb/tb_bus_width_matcher.sv
module tb_bus_width_matcher;

  localparam int HW = 9;
  localparam int FW = 2 * HW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrNarrow = 1'b0, cfgRdNarrow = 1'b0, cfgBigEnd = 1'b0;
  logic inValid = 1'b0, outReady = 1'b0;
  logic inReady, outValid;
  logic [FW-1:0] inData = '0;
  logic [FW-1:0] outData;

  int nTests = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  bus_width_matcher #(.HALF_W(HW)) dut (
    .clk(clk), .rstN(rstN), .cfgWrNarrow(cfgWrNarrow), .cfgRdNarrow(cfgRdNarrow),
    .cfgBigEnd(cfgBigEnd), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  task automatic check(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(logic wrN, logic rdN, logic big);
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b0;
    cfgWrNarrow = wrN; cfgRdNarrow = rdN; cfgBigEnd = big;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    cfgWrNarrow = !wrN; cfgRdNarrow = !rdN; cfgBigEnd = !big;
  endtask

  task automatic push(logic [FW-1:0] d);
    @(negedge clk);
    inValid = 1'b1; inData = d;
    #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic pop(output logic [FW-1:0] d);
    @(negedge clk);
    outReady = 1'b1;
    #1;
    while (!outValid) begin @(negedge clk); #1; end
    d = outData;
    @(posedge clk); #1;
    outReady = 1'b0;
  endtask

  task automatic testWideWide();
    logic [FW-1:0] got;
    doReset(1'b0, 1'b0, 1'b1);
    @(negedge clk); #1;
    check("R9 reset outValid", {17'd0, outValid}, '0);
    for (int i = 0; i < 3; i++) begin
      push(18'h2A5C3 + FW'(i * 18'h1111));
      pop(got);
      check("R2 wide pass", got, 18'h2A5C3 + FW'(i * 18'h1111));
    end
  endtask

  task automatic testSplit(logic big);
    logic [FW-1:0] got, w;
    doReset(1'b0, 1'b1, big);
    w = 18'h3_5A_7E ^ (big ? 18'h00F0F : 18'h0);
    push(w);
    #1; check("R10 closed after load", {17'd0, inReady}, '0);
    pop(got);
    check(big ? "R3 first half" : "R4 first half", got, big ? {9'd0, w[17:9]} : {9'd0, w[8:0]});
    pop(got);
    check(big ? "R3 second half" : "R4 second half", got, big ? {9'd0, w[8:0]} : {9'd0, w[17:9]});
  endtask

  task automatic testPack(logic big);
    logic [FW-1:0] got;
    logic [HW-1:0] a, b;
    a = 9'h1C5; b = 9'h03A;
    doReset(1'b1, 1'b0, big);
    push({9'h1FF, a});
    @(negedge clk); #1;
    check("R6 partial hidden", {17'd0, outValid}, '0);
    push({9'h155, b});
    pop(got);
    check("R5 packed word", got, big ? {a, b} : {b, a});
  endtask

  task automatic testNarrowNarrow();
    logic [FW-1:0] got;
    doReset(1'b1, 1'b1, 1'b1);
    push(18'h3FE01);
    pop(got);
    check("R7 narrow pass 1", got, 18'h00001);
    push(18'h2A1F0);
    pop(got);
    check("R7 narrow pass 2", got, 18'h001F0);
  endtask

  task automatic testStall();
    logic [FW-1:0] got;
    doReset(1'b0, 1'b1, 1'b1);
    push(18'h2B4C7);
    pop(got);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R8 valid held", {17'd0, outValid}, 18'd1);
      check("R8 data held", outData, {9'd0, 9'h0C7});
      check("R10 input closed", {17'd0, inReady}, '0);
    end
    pop(got);
  endtask

  task automatic testResetMidPack();
    logic [FW-1:0] got;
    doReset(1'b1, 1'b0, 1'b1);
    push(18'h000AA);
    doReset(1'b1, 1'b0, 1'b1);
    @(negedge clk); #1;
    check("R9 no stale word", {17'd0, outValid}, '0);
    push(18'h00111);
    push(18'h00022);
    pop(got);
    check("R9 fresh pack", got, {9'h111, 9'h022});
  endtask

  task automatic testCfgIgnored();
    logic [FW-1:0] got;
    doReset(1'b0, 1'b1, 1'b0);
    cfgWrNarrow = 1'b1; cfgRdNarrow = 1'b0; cfgBigEnd = 1'b1;
    push(18'h1F00E);
    pop(got);
    check("R1 mode kept, first", got, {9'd0, 9'h00E});
    pop(got);
    check("R1 mode kept, second", got, {9'd0, 9'h0F8});
  endtask

  initial begin
    testWideWide();
    testSplit(1'b1);
    testSplit(1'b0);
    testPack(1'b1);
    testPack(1'b0);
    testNarrowNarrow();
    testStall();
    testResetMidPack();
    testCfgIgnored();
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule